// File: doc/BRIEF.md
# Serial Delay-Code Loader

This block takes 8-bit command words from a three-wire serial link and stores them in per-channel delay registers. The link has an active-low enable, a serial clock and a data line. Three channels each hold a 5-bit delay code, and a separate test register holds a 4-bit slice-level code. All three serial inputs are asynchronous to the system clock. Each passes through a synchronizer, and edges are detected in the system clock domain.

Inside one enable window the host may stream as many words as it likes. Each group of eight falling serial-clock edges forms one word, with the first bit received being the most significant. The bit count restarts every time the enable line goes active, so a host that has lost alignment only needs to open a new window. When the enable line is released after a window that wrote a register, the block raises a one-cycle calibration request for the analog stage further down.

Top module: `sdl_ctrl`

## Requirements
- R1: After reset, the three delay codes, the slice code and `cal_start_o` are all 0.
- R2: Data is sampled on each falling edge of `ser_clk_i` while `ser_en_n_i` is low. The first bit sampled in a window is bit 7, the most significant bit of the word.
- R3: A word has the layout bit 7 = 0, bits 6..5 = select, bits 4..0 = delay code. Select 01 writes `dly_r_o`, 10 writes `dly_g_o` and 11 writes `dly_b_o`. The other channels keep their values.
- R4: Select 00 writes the test register: `slice_o` takes word bits 4..1 and word bit 0 is ignored. No delay code changes.
- R5: After every eighth falling edge, the next edge begins a new word. Three words sent back to back in one window load all three channels.
- R6: A falling edge on `ser_en_n_i` clears the bit count, so bits left over from an earlier window never combine with later bits.
- R7: A window that closes with fewer than 8 bits pending writes no register.
- R8: A word whose bit 7 is 1 writes no register, but it still takes up eight bit positions, so the word after it in the same window is decoded normally.
- R9: `cal_start_o` goes high for exactly one cycle after a rising edge on `ser_en_n_i`, but only if the window that just closed wrote at least one register. Otherwise it stays low.
- R10: Serial clock edges while `ser_en_n_i` is high leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous; idles high |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_en_n_i | input | 1 | Serial enable, active low, asynchronous |
| dly_r_o | output | 5 | Delay code, channel R (select 01) |
| dly_g_o | output | 5 | Delay code, channel G (select 10) |
| dly_b_o | output | 5 | Delay code, channel B (select 11) |
| slice_o | output | 4 | Slice-level code from the test register |
| cal_start_o | output | 1 | One-cycle calibration request |

## Verification
The bench uses the default parameters: a two-stage synchronizer, 8-bit words, 5-bit delay codes and a 4-bit slice code. Each serial half-period lasts three system clocks, which keeps every serial edge clear of the synchronizer delay. With this word width, a random count of trailing bits from 0 to 7 covers every possible partial-word state at window close. Word alignment and the resync on enable are therefore exercised at all bit positions. The random windows mix leading-1 words, test-register words and channel words, so the calibration decision is checked against windows that do and do not write.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
   // select field values of a command word
   typedef enum logic [1:0] {
      SEL_TEST = 2'b00,
      SEL_CH0  = 2'b01,
      SEL_CH1  = 2'b10,
      SEL_CH2  = 2'b11
   } sel_e;

   localparam int unsigned WORD_W_DEF  = 8;
   localparam int unsigned DELAY_W_DEF = 5;
   localparam int unsigned SLICE_W_DEF = 4;
   localparam int unsigned SYNC_N_DEF  = 2;

   // index of each serial input inside the synchronizer vector
   localparam int unsigned IDX_DAT = 0;
   localparam int unsigned IDX_CLK = 1;
   localparam int unsigned IDX_EN  = 2;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
   parameter int unsigned N_SIG     = 3,
   parameter int unsigned STAGES    = 2,
   parameter logic [N_SIG-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SIG-1:0] async_i,
   output logic [N_SIG-1:0] sync_o,
   output logic [N_SIG-1:0] rise_o,
   output logic [N_SIG-1:0] fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdl_sync: STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar s = 0; s < N_SIG; s++) begin : g_sig
         logic [STAGES-1:0] chain;
         logic              last_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain  <= {STAGES{RST_VAL[s]}};
               last_q <= RST_VAL[s];
            end else begin
               chain  <= {chain[STAGES-2:0], async_i[s]};
               last_q <= chain[STAGES-1];
            end
         end

         assign sync_o[s] = chain[STAGES-1];
         assign rise_o[s] = chain[STAGES-1] & ~last_q;
         assign fall_o[s] = ~chain[STAGES-1] & last_q;
      end
   endgenerate
endmodule

// File: rtl/sdl_shift.sv
module sdl_shift #(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_active,
   input  logic              en_fall,
   input  logic              sclk_fall,
   input  logic              dat,
   output logic [WORD_W-1:0] word_o,
   output logic              word_stb_o,
   output logic [$clog2(WORD_W)-1:0] bit_cnt_o
);
   localparam int unsigned CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   generate
      if (WORD_W < 4) begin : g_bad_word
         $error("sdl_shift: WORD_W too small");
      end
   endgenerate

   logic [WORD_W-1:0] shreg_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              take_bit;

   assign take_bit   = en_active & sclk_fall & ~en_fall;
   assign word_o     = {shreg_q[WORD_W-2:0], dat};
   assign word_stb_o = take_bit & (cnt_q == LAST_BIT);
   assign bit_cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (en_fall) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (take_bit) begin
         shreg_q <= word_o;
         cnt_q   <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sdl_regs.sv
module sdl_regs #(
   parameter int unsigned WORD_W  = 8,
   parameter int unsigned DELAY_W = 5,
   parameter int unsigned SLICE_W = 4,
   parameter int unsigned NUM_CH  = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [WORD_W-1:0]                word_i,
   input  logic                             word_stb_i,
   input  logic                             en_rise_i,
   output logic [NUM_CH-1:0][DELAY_W-1:0]   dly_o,
   output logic [SLICE_W-1:0]               slice_o,
   output logic                             cal_start_o
);
   import sdl_pkg::*;

   localparam int unsigned SEL_W = WORD_W - 1 - DELAY_W;

   generate
      if (SEL_W != 2) begin : g_bad_sel
         $error("sdl_regs: select field must be 2 bits");
      end
      if (NUM_CH > 3) begin : g_bad_ch
         $error("sdl_regs: too many channels for the select field");
      end
      if (SLICE_W + 1 > DELAY_W) begin : g_bad_slice
         $error("sdl_regs: slice code does not fit the payload");
      end
   endgenerate

   logic             lead;
   logic [1:0]       sel;
   logic [DELAY_W-1:0] payload;
   logic             accept;
   logic             wr_now;
   logic             pend_q;

   assign lead    = word_i[WORD_W-1];
   assign sel     = word_i[WORD_W-2 -: 2];
   assign payload = word_i[DELAY_W-1:0];
   assign accept  = word_stb_i & ~lead;
   assign wr_now  = accept & ((sel == SEL_TEST) | (int'(sel) <= NUM_CH));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dly_o[c] <= '0;
            else if (accept && int'(sel) == c + 1)
               dly_o[c] <= payload;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slice_o <= '0;
      else if (accept && sel == SEL_TEST)
         slice_o <= payload[SLICE_W:1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         cal_start_o <= 1'b0;
      end else begin
         cal_start_o <= en_rise_i & (pend_q | wr_now);
         if (en_rise_i)
            pend_q <= 1'b0;
         else if (wr_now)
            pend_q <= 1'b1;
      end
   end
endmodule

// File: rtl/sdl_ctrl.sv
module sdl_ctrl #(
   parameter int unsigned SYNC_N  = sdl_pkg::SYNC_N_DEF,
   parameter int unsigned WORD_W  = sdl_pkg::WORD_W_DEF,
   parameter int unsigned DELAY_W = sdl_pkg::DELAY_W_DEF,
   parameter int unsigned SLICE_W = sdl_pkg::SLICE_W_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk_i,
   input  logic               ser_dat_i,
   input  logic               ser_en_n_i,
   output logic [DELAY_W-1:0] dly_r_o,
   output logic [DELAY_W-1:0] dly_g_o,
   output logic [DELAY_W-1:0] dly_b_o,
   output logic [SLICE_W-1:0] slice_o,
   output logic               cal_start_o
);
   import sdl_pkg::*;

   localparam int unsigned NUM_CH = 3;
   localparam int unsigned CNT_W  = $clog2(WORD_W);
   // idle levels: enable high, clock high, data low
   localparam logic [2:0] SYNC_RST = 3'b110;

   logic [2:0] raw_in, s_lvl, s_rise, s_fall;
   logic       en_sync, en_fall, en_rise, sclk_fall, dat_sync;
   logic [WORD_W-1:0] word;
   logic       word_stb;
   logic [CNT_W-1:0] bit_cnt;
   logic [NUM_CH-1:0][DELAY_W-1:0] dly;

   assign raw_in[IDX_DAT] = ser_dat_i;
   assign raw_in[IDX_CLK] = ser_clk_i;
   assign raw_in[IDX_EN]  = ser_en_n_i;

   sdl_sync #(.N_SIG(3), .STAGES(SYNC_N), .RST_VAL(SYNC_RST)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(raw_in),
      .sync_o (s_lvl),
      .rise_o (s_rise),
      .fall_o (s_fall)
   );

   assign en_sync   = s_lvl[IDX_EN];
   assign en_fall   = s_fall[IDX_EN];
   assign en_rise   = s_rise[IDX_EN];
   assign sclk_fall = s_fall[IDX_CLK];
   assign dat_sync  = s_lvl[IDX_DAT];

   sdl_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_active (~en_sync),
      .en_fall   (en_fall),
      .sclk_fall (sclk_fall),
      .dat       (dat_sync),
      .word_o    (word),
      .word_stb_o(word_stb),
      .bit_cnt_o (bit_cnt)
   );

   sdl_regs #(.WORD_W(WORD_W), .DELAY_W(DELAY_W), .SLICE_W(SLICE_W), .NUM_CH(NUM_CH)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_i     (word),
      .word_stb_i (word_stb),
      .en_rise_i  (en_rise),
      .dly_o      (dly),
      .slice_o    (slice_o),
      .cal_start_o(cal_start_o)
   );

   assign dly_r_o = dly[0];
   assign dly_g_o = dly[1];
   assign dly_b_o = dly[2];
endmodule

// File: rtl/sdl_chk.sv
module sdl_chk #(
   parameter int unsigned WORD_W  = 8,
   parameter int unsigned DELAY_W = 5,
   parameter int unsigned SLICE_W = 4,
   parameter int unsigned CNT_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_sync,
   input logic               en_fall,
   input logic [CNT_W-1:0]   bit_cnt,
   input logic               word_stb,
   input logic [WORD_W-1:0]  word,
   input logic [DELAY_W-1:0] dly_r,
   input logic [DELAY_W-1:0] dly_g,
   input logic [DELAY_W-1:0] dly_b,
   input logic [SLICE_W-1:0] slice,
   input logic               cal_start
);
   a_r9_cal_single: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |=> !cal_start);

   a_r9_cal_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start |-> en_sync);

   a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      en_sync |=> ($stable(dly_r) && $stable(dly_g) && $stable(dly_b) && $stable(slice)));

   a_r6_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      en_fall |=> (bit_cnt == '0));

   a_r8_lead_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && word[WORD_W-1]) |=>
      ($stable(dly_r) && $stable(dly_g) && $stable(dly_b) && $stable(slice)));
endmodule

bind sdl_ctrl sdl_chk #(
   .WORD_W(WORD_W), .DELAY_W(DELAY_W), .SLICE_W(SLICE_W), .CNT_W(CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_sync  (en_sync),
   .en_fall  (en_fall),
   .bit_cnt  (bit_cnt),
   .word_stb (word_stb),
   .word     (word),
   .dly_r    (dly_r_o),
   .dly_g    (dly_g_o),
   .dly_b    (dly_b_o),
   .slice    (slice_o),
   .cal_start(cal_start_o)
);

// File: tb/tb_sdl_ctrl.sv
module tb_sdl_ctrl;
   localparam int HALF = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b1, ser_dat = 1'b0, ser_en_n = 1'b1;
   logic [4:0] dly_r, dly_g, dly_b;
   logic [3:0] slice;
   logic cal_start;

   int n_run = 0, n_fail = 0, cal_cnt = 0;
   bit done = 0;

   // bench model
   logic [4:0] m_d [3];
   logic [3:0] m_s;
   logic [7:0] m_sh;
   int         m_cnt;
   bit         m_wrote;

   always #4 clk = ~clk;

   sdl_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
      .ser_en_n_i(ser_en_n), .dly_r_o(dly_r), .dly_g_o(dly_g), .dly_b_o(dly_b),
      .slice_o(slice), .cal_start_o(cal_start)
   );

   always @(negedge clk) if (cal_start) cal_cnt++;

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // model of one decoded word
   task automatic model_word(logic [7:0] w);
      if (!w[7]) begin
         m_wrote = 1;
         if (w[6:5] == 2'b00) m_s = w[4:1];
         else m_d[w[6:5]-1] = w[4:0];
      end
   endtask

   task automatic send_bit(logic b);
      ser_dat = b;
      wait_cyc(HALF);
      ser_clk = 1'b0;
      wait_cyc(HALF);
      ser_clk = 1'b1;
      if (!ser_en_n) begin
         m_sh = {m_sh[6:0], b};
         m_cnt++;
         if (m_cnt == 8) begin
            m_cnt = 0;
            model_word(m_sh);
         end
      end
   endtask

   task automatic send_word(logic [7:0] w);
      for (int i = 7; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic open_win();
      ser_en_n = 1'b0;
      m_cnt = 0; m_sh = '0; m_wrote = 0;
      wait_cyc(2*HALF);
   endtask

   int cal_before;
   task automatic close_win(string tag);
      wait_cyc(HALF);
      ser_en_n = 1'b1;
      wait_cyc(12);
      check({tag, " R3 dly_r"}, dly_r, m_d[0]);
      check({tag, " R3 dly_g"}, dly_g, m_d[1]);
      check({tag, " R3 dly_b"}, dly_b, m_d[2]);
      check({tag, " R4 slice"}, slice, m_s);
      check({tag, " R9 cal pulses"}, cal_cnt - cal_before, m_wrote ? 1 : 0);
      cal_before = cal_cnt;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      wait_cyc(150000);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5D1C));
      for (int i = 0; i < 3; i++) m_d[i] = '0;
      m_s = '0; m_cnt = 0; m_sh = '0; m_wrote = 0;
      cal_before = 0;
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(4);
      // R1 reset state
      check("R1 dly_r", dly_r, 0);
      check("R1 dly_g", dly_g, 0);
      check("R1 dly_b", dly_b, 0);
      check("R1 slice", slice, 0);
      check("R1 cal", cal_cnt, 0);

      // R2 MSB first, R3 channel R
      open_win(); send_word(8'b0_01_10101); close_win("R2 single word");
      check("R2 dly_r value", dly_r, 21);
      open_win(); send_word(8'b0_10_00011); close_win("R3 green");
      open_win(); send_word(8'b0_11_11111); close_win("R3 blue");
      // R4 test register, LSB set to 1 to show it is ignored
      open_win(); send_word(8'b0_00_1011_1); close_win("R4 test reg");
      check("R4 slice value", slice, 11);
      // R5 streaming three words
      open_win();
      send_word(8'b0_01_00001); send_word(8'b0_10_00010); send_word(8'b0_11_00100);
      close_win("R5 stream");
      check("R5 dly_b value", dly_b, 4);
      // R7 partial word
      open_win();
      for (int i = 0; i < 5; i++) send_bit(1'b0);
      close_win("R7 partial");
      // R6 resync: leftover bits then a clean window
      open_win(); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); close_win("R6 leftovers");
      open_win(); send_word(8'b0_01_01110); close_win("R6 resync");
      check("R6 dly_r value", dly_r, 14);
      // R8 lead-one word keeps alignment
      open_win(); send_word(8'b1_10_11111); send_word(8'b0_10_01010); close_win("R8 aligned");
      check("R8 dly_g value", dly_g, 10);
      open_win(); send_word(8'b1_11_00000); close_win("R8 only ignored");
      // R10 serial clocks with enable high
      for (int i = 0; i < 16; i++) send_bit(1'(i));
      cal_before = cal_cnt;
      check("R10 dly_r idle", dly_r, m_d[0]);
      check("R10 dly_g idle", dly_g, m_d[1]);
      check("R10 dly_b idle", dly_b, m_d[2]);
      check("R10 slice idle", slice, m_s);

      // random windows
      for (int k = 0; k < 40; k++) begin
         int nw, nb;
         nw = $urandom_range(0, 3);
         nb = $urandom_range(0, 7);
         open_win();
         for (int j = 0; j < nw; j++) begin
            logic [7:0] w;
            w = 8'($urandom);
            if ($urandom_range(0, 3) != 0) w[7] = 1'b0;
            send_word(w);
         end
         for (int j = 0; j < nb; j++) send_bit(1'($urandom));
         close_win("R5 random");
      end
      finish_run();
   end
endmodule